// File: doc/BRIEF.md
# Indirect RAM Pointer Register Bank

This block is the host-facing register bank of a network controller whose packet RAM is reachable only through an address pointer. A microcontroller bus with a 3-bit register address, an 8-bit write bus and separate write and read strobes programs the pointer. The host writes a high pointer byte and then a low pointer byte. Only the low-byte write moves the RAM address that the block drives out.

The high pointer byte also carries a DMA enable. A low-byte write with that enable set raises a level DMA request, which stays up until the DMA engine acknowledges it or the host clears the enable. In 16-bit access mode, bit 0 of the committed pointer stops acting as an address bit and instead requests a swap of the two data bytes.

A configuration register and a sub-address register share a 2-bit register select. A third select bit, held only in the sub-address register, switches the shared paged address between two groups of setup registers. Any configuration write clears that third bit.

Top module: `ptr_regbank`

## Requirements
- R1: Only synchronous reset affects the configuration register (offset 0), which resets to 8'h18. The selected paged register (offset 4) reads 8'h00 after reset, and `dma_req` is low.
- R2: A write to pointer-high (offset 2) leaves `ram_addr` unchanged. A write to pointer-low (offset 3) sets `ram_addr` to {pointer-high[2:0], low byte} on the clock edge of that write.
- R3: Reading pointer-high returns the whole stored byte, including the DMA enable at bit 3. Reading pointer-low returns the byte last written.
- R4: A pointer-low write raises `dma_req` on the same edge when pointer-high bit 3 is set. It leaves `dma_req` low when that bit is clear.
- R5: `dma_req` stays high until `dma_ack` is sampled high or pointer-high is written with bit 3 clear.
- R6: Configuration bit 2 selects 16-bit mode. When it is clear, `swap_bytes` is 0 and `ram_addr[0]` equals committed pointer bit 0. When it is set, `ram_addr[0]` is 0 and `swap_bytes` equals committed pointer bit 0.
- R7: Configuration bits [1:0] and sub-address bits [1:0] are one shared select. A write through either register is seen when the other is read.
- R8: Sub-address bit 2 is the page select and is set by a sub-address write. Any configuration write clears it.
- R9: Sub-address bits [7:3] always read as zero, whatever was written to them.
- R10: The paged register at offset 4 is chosen by {page, select}. Page 0 holds setup-1 and three auxiliary registers at selects 0 to 3. Page 1 holds setup-2, bus control and DMA count at selects 0 to 2. Page 1 select 3 reads zero and ignores writes.
- R11: `bus_rdata` takes the addressed register's value on the edge where `bus_rd` is sampled high, and holds it at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| dma_ack | input | 1 | DMA acknowledge, clears the request |
| dma_req | output | 1 | Level DMA request |
| ram_addr | output | 11 | Committed packet RAM address |
| swap_bytes | output | 1 | Byte swap request in 16-bit mode |
| wide_mode | output | 1 | 16-bit access mode flag |

## Verification
A high byte that leaks into the committed pointer shows on `ram_addr` one edge after the pointer-high write, so the bench checks the address both before and after the low byte is written. A desynchronised shared select or a page bit that fails to clear appears on the next read of the other register or of offset 4. The bench therefore reads both views right after each write. A mis-armed DMA request shows on `dma_req` at the edge of the low write, and a release that is stuck or early shows within one cycle of the acknowledge or the enable clear.

// File: rtl/ptr_regbank_pkg.sv
package ptr_regbank_pkg;
  localparam int BUS_AW = 3;
  localparam int DW     = 8;

  typedef enum logic [BUS_AW-1:0] {
    REG_CFG  = 3'd0,
    REG_SUB  = 3'd1,
    REG_PHI  = 3'd2,
    REG_PLO  = 3'd3,
    REG_PAGE = 3'd4
  } reg_off_e;

  localparam logic [DW-1:0] CFG_RESET = 8'h18;
endpackage

// File: rtl/ptr_regbank_ptr.sv
module ptr_regbank_ptr #(
  parameter int RAM_AW = 11,
  parameter int DW     = 8,
  parameter int EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DW-1:0]     wdata,
  input  logic              dma_ack,
  input  logic              wide_mode,
  output logic [DW-1:0]     hi_q,
  output logic [DW-1:0]     lo_q,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              swap_bytes,
  output logic              dma_req
);
  localparam int HI_W = RAM_AW - DW;

  logic [RAM_AW-1:0] ptr_q;

  // staged high byte, committed only by the low byte
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (wr_hi) hi_q <= wdata;
      if (wr_lo) begin
        lo_q  <= wdata;
        ptr_q <= {hi_q[HI_W-1:0], wdata};
      end
    end
  end

  // level request: arming has priority over release
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req <= 1'b0;
    end else if (wr_lo && hi_q[EN_BIT]) begin
      dma_req <= 1'b1;
    end else if (dma_ack || (wr_hi && !wdata[EN_BIT])) begin
      dma_req <= 1'b0;
    end
  end

  assign ram_addr   = {ptr_q[RAM_AW-1:1], ptr_q[0] & ~wide_mode};
  assign swap_bytes = ptr_q[0] & wide_mode;
endmodule

// File: rtl/ptr_regbank_sel.sv
module ptr_regbank_sel #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] CFG_RST    = 8'h18,
  parameter int            WIDE_BIT   = 2,
  parameter logic [7:0]    SLOT_MASK  = 8'b0111_1111
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cfg,
  input  logic          wr_sub,
  input  logic          wr_page,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_view,
  output logic [DW-1:0] sub_view,
  output logic [DW-1:0] page_view,
  output logic          wide_mode,
  output logic          page_hi
);
  localparam int SEL_W  = 2;
  localparam int SLOTS  = 2 ** (SEL_W + 1);

  logic [DW-1:SEL_W]   cfg_hi_q;
  logic [SEL_W-1:0]    sel_q;
  logic [SEL_W:0]      slot_idx;
  logic [DW-1:0]       slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_hi_q <= CFG_RST[DW-1:SEL_W];
      sel_q    <= CFG_RST[SEL_W-1:0];
      page_hi  <= 1'b0;
    end else if (wr_cfg) begin
      cfg_hi_q <= wdata[DW-1:SEL_W];
      sel_q    <= wdata[SEL_W-1:0];
      page_hi  <= 1'b0;
    end else if (wr_sub) begin
      sel_q    <= wdata[SEL_W-1:0];
      page_hi  <= wdata[SEL_W];
    end
  end

  assign slot_idx = {page_hi, sel_q};

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (SLOT_MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)                                 slot_q[i] <= '0;
        else if (wr_page && slot_idx == (SEL_W+1)'(i)) slot_q[i] <= wdata;
      end
    end else begin : g_hole
      always_ff @(posedge clk) slot_q[i] <= '0;
    end
  end

  assign page_view = slot_q[slot_idx];
  assign cfg_view  = {cfg_hi_q, sel_q};
  assign sub_view  = {{(DW-SEL_W-1){1'b0}}, page_hi, sel_q};
  assign wide_mode = cfg_hi_q[WIDE_BIT];
endmodule

// File: rtl/ptr_regbank.sv
module ptr_regbank
  import ptr_regbank_pkg::*;
#(
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              swap_bytes,
  output logic              wide_mode
);
  logic [DW-1:0] hi_q, lo_q, cfg_view, sub_view, page_view, rd_mux;
  logic          page_hi;
  logic          wr_cfg, wr_sub, wr_hi, wr_lo, wr_page;

  assign wr_cfg  = bus_wr && (bus_addr == REG_CFG);
  assign wr_sub  = bus_wr && (bus_addr == REG_SUB);
  assign wr_hi   = bus_wr && (bus_addr == REG_PHI);
  assign wr_lo   = bus_wr && (bus_addr == REG_PLO);
  assign wr_page = bus_wr && (bus_addr == REG_PAGE);

  ptr_regbank_ptr #(.RAM_AW(RAM_AW), .DW(DW), .EN_BIT(3)) ptr_i (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(bus_wdata),
    .dma_ack(dma_ack), .wide_mode(wide_mode), .hi_q(hi_q), .lo_q(lo_q),
    .ram_addr(ram_addr), .swap_bytes(swap_bytes), .dma_req(dma_req)
  );

  ptr_regbank_sel #(.DW(DW), .CFG_RST(CFG_RESET)) sel_i (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_sub(wr_sub), .wr_page(wr_page),
    .wdata(bus_wdata), .cfg_view(cfg_view), .sub_view(sub_view),
    .page_view(page_view), .wide_mode(wide_mode), .page_hi(page_hi)
  );

  always_comb begin
    case (bus_addr)
      REG_CFG:  rd_mux = cfg_view;
      REG_SUB:  rd_mux = sub_view;
      REG_PHI:  rd_mux = hi_q;
      REG_PLO:  rd_mux = lo_q;
      REG_PAGE: rd_mux = page_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ptr_regbank_chk.sv
module ptr_regbank_chk
  import ptr_regbank_pkg::*;
#(
  parameter int RAM_AW = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_rdata,
  input logic              dma_ack,
  input logic              dma_req,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              swap_bytes,
  input logic              wide_mode,
  input logic              page_hi
);
  assert_hi_no_commit_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_PHI) |=> $stable(ram_addr));

  assert_dma_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(bus_wr && bus_addr == REG_PLO));

  assert_dma_release_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_ack && !(bus_wr && bus_addr == REG_PLO)) |=> !dma_req);

  assert_narrow_noswap_R6: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> !swap_bytes);

  assert_wide_even_R6: assert property (@(posedge clk) disable iff (rst)
    wide_mode |-> !ram_addr[0]);

  assert_page_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_CFG) |=> !page_hi);

  assert_sub_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_SUB) |=> (bus_rdata[7:3] == 5'd0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind ptr_regbank ptr_regbank_chk #(.RAM_AW(RAM_AW)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .dma_ack(dma_ack), .dma_req(dma_req),
  .ram_addr(ram_addr), .swap_bytes(swap_bytes), .wide_mode(wide_mode),
  .page_hi(page_hi)
);

// File: tb/ptr_regbank_tb_top.sv
module ptr_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        dma_ack = 1'b0;
  logic        dma_req;
  logic [10:0] ram_addr;
  logic        swap_bytes;
  logic        wide_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptr_regbank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dma_ack(dma_ack), .dma_req(dma_req), .ram_addr(ram_addr),
    .swap_bytes(swap_bytes), .wide_mode(wide_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d); chk("R1 cfg reset", d, 8'h18);
    rd(3'd4, d); chk("R1 setup1 reset", d, 8'h00);
    chk("R1 dma_req reset", dma_req, 1'b0);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    wr(3'd2, 8'h05); chk("R2 hi alone", ram_addr, 11'h000);
    wr(3'd3, 8'h3C); chk("R2 commit", ram_addr, 11'h53C);
    rd(3'd2, d); chk("R3 hi read", d, 8'h05);
    rd(3'd3, d); chk("R3 lo read", d, 8'h3C);
    wr(3'd2, 8'h02); chk("R2 hi rewrite", ram_addr, 11'h53C);
    chk("R4 no enable", dma_req, 1'b0);
  endtask

  task automatic t_dma();
    logic [7:0] d;
    wr(3'd2, 8'h0B); chk("R4 hi write no req", dma_req, 1'b0);
    wr(3'd3, 8'h10); chk("R4 armed", dma_req, 1'b1);
    chk("R2 commit 2", ram_addr, 11'h310);
    rd(3'd2, d); chk("R3 enable readback", d, 8'h0B);
    repeat (3) @(negedge clk);
    chk("R5 held", dma_req, 1'b1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk("R5 ack release", dma_req, 1'b0);
    wr(3'd3, 8'h11); chk("R4 rearm", dma_req, 1'b1);
    wr(3'd2, 8'h03); chk("R5 enable clear", dma_req, 1'b0);
    wr(3'd3, 8'h11); chk("R4 disabled", dma_req, 1'b0);
  endtask

  task automatic t_swap();
    chk("R6 narrow addr", ram_addr, 11'h311);
    chk("R6 narrow swap", swap_bytes, 1'b0);
    wr(3'd0, 8'h1C);
    chk("R6 wide addr", ram_addr, 11'h310);
    chk("R6 wide swap", swap_bytes, 1'b1);
    wr(3'd3, 8'h20);
    chk("R6 wide even swap", swap_bytes, 1'b0);
    chk("R6 wide even addr", ram_addr, 11'h320);
    wr(3'd0, 8'h18);
  endtask

  task automatic t_subaddr();
    logic [7:0] d;
    wr(3'd1, 8'h02); rd(3'd0, d); chk("R7 sub to cfg", d, 8'h1A);
    wr(3'd0, 8'h19); rd(3'd1, d); chk("R7 cfg to sub", d, 8'h01);
    wr(3'd1, 8'hFD); rd(3'd1, d); chk("R9 upper zero", d, 8'h05);
    rd(3'd0, d); chk("R7 cfg view", d, 8'h19);
    wr(3'd0, 8'h19); rd(3'd1, d); chk("R8 page cleared", d, 8'h01);
  endtask

  task automatic t_paged();
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 8'(s)); wr(3'd4, 8'hA0 + 8'(s));
    end
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 8'h04 + 8'(s)); wr(3'd4, 8'hB0 + 8'(s));
    end
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 8'(s)); rd(3'd4, d); chk("R10 page0", d, 8'hA0 + 8'(s));
    end
    for (int s = 0; s < 3; s++) begin
      wr(3'd1, 8'h04 + 8'(s)); rd(3'd4, d); chk("R10 page1", d, 8'hB0 + 8'(s));
    end
    wr(3'd1, 8'h07); rd(3'd4, d); chk("R10 hole", d, 8'h00);
    wr(3'd0, 8'h18); rd(3'd4, d); chk("R8 R10 cfg returns page0", d, 8'hA0);
  endtask

  task automatic t_rdhold();
    logic [7:0] d;
    rd(3'd2, d); chk("R11 read", d, 8'h03);
    wr(3'd2, 8'h07);
    chk("R11 hold", bus_rdata, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pointer();
    t_dma();
    t_swap();
    t_subaddr();
    t_paged();
    t_rdhold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule